// File: doc/BRIEF.md
# Exception Stacking Sequencer

This block saves processor state when an exception is taken. On an accepted request it writes the status word and then the program counter below the current stack pointer. Each write first lowers the pointer by 4. It then reads the handler address as a 32-bit word from the vector table, at the table base plus four times the vector number. The caller gets a one-cycle completion pulse that carries the handler address, the vector that was finally taken and the updated stack pointer.

Every stack write is checked for word alignment, and the table base is checked as well. A misaligned stack write is still put on the bus at the misaligned address. The fault is only recorded as pending. When the current sequence has finished its vector read, the sequencer runs a second stacking pass for the address-error vector. In that pass it pushes the status word and the first handler address, and it checks no alignment at all. The nested pass therefore always ends at the address-error handler.

Top module: `exc_stacker`

## Requirements
- R1: After reset the block is idle: busy, bus write strobe, bus read strobe, done and addr_err are 0, and sp_out is 0.
- R2: An accepted request issues a write of sr_in at address sp_in-4, then a write of pc_in at address sp_in-8. These are the first two bus cycles of the sequence.
- R3: After the two writes, a read is issued at vbr_in + 4*req_vec. After a fault-free sequence, done pulses for exactly one cycle with handler equal to the read data, done_vec equal to req_vec and sp_out equal to sp_in-8.
- R4: Each bus cycle holds its address, data and strobe unchanged until the cycle in which bus_ready is 1, and it completes in that cycle.
- R5: A stack write whose address has nonzero low two bits is still issued on the bus at that exact address.
- R6: A fault is a stack write with nonzero low two bits, or a vector read with vbr_in bits [1:0] nonzero. A fault does not cut the sequence short, and addr_err is 1 from the end of the first faulty stack write until the vector read completes. After that read, the block writes the status word at sp_in-12, writes the first handler address at sp_in-16, and reads at vbr_in + 4*AE_VEC.
- R7: During address-error stacking no fault is detected. The sequence ends with a single done pulse, with done_vec = AE_VEC, handler equal to the second read data, sp_out = sp_in-16, and addr_err at 0.
- R8: A request made while busy is 1 is ignored: it issues no bus cycle and produces no done pulse, and done_vec still reports the vector of the running sequence.
- R9: Because the pointer only moves in steps of 4, sp_out bits [1:0] at done equal sp_in bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Exception request, accepted when idle |
| req_vec | input | VW | Vector number of the request |
| sr_in | input | 32 | Status word to save |
| pc_in | input | 32 | Program counter to save |
| sp_in | input | 32 | Stack pointer at the request |
| vbr_in | input | 32 | Vector table base |
| busy | output | 1 | A sequence is in progress |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_we | output | 1 | Write cycle active |
| bus_re | output | 1 | Read cycle active |
| bus_rdata | input | 32 | Read data |
| bus_ready | input | 1 | Completes the current bus cycle |
| sp_out | output | 32 | Updated stack pointer |
| addr_err | output | 1 | Address error pending |
| done | output | 1 | One-cycle completion pulse |
| handler | output | 32 | Fetched handler address |
| done_vec | output | VW | Vector finally taken |

## Verification
The bench builds the block with VW=8 and AE_VEC=9. It sweeps all sixteen combinations of the stack pointer's and table base's low two bits, three vector numbers (0, 5 and 255) and bus latencies of 0 to 2 wait cycles. This covers every mix of aligned and misaligned pointer and base, together with the edge vector numbers. In every run it compares the whole bus trace and the completion outputs with values it computes from sp_in and vbr_in. Midway through each run it sends a second request to check that requests made while busy are ignored.

// File: rtl/exc_stacker.sv
module exc_stacker #(
  parameter int VW     = 8,
  parameter int AE_VEC = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [VW-1:0] req_vec,
  input  logic [31:0]   sr_in,
  input  logic [31:0]   pc_in,
  input  logic [31:0]   sp_in,
  input  logic [31:0]   vbr_in,
  output logic          busy,
  output logic [31:0]   bus_addr,
  output logic [31:0]   bus_wdata,
  output logic          bus_we,
  output logic          bus_re,
  input  logic [31:0]   bus_rdata,
  input  logic          bus_ready,
  output logic [31:0]   sp_out,
  output logic          addr_err,
  output logic          done,
  output logic [31:0]   handler,
  output logic [VW-1:0] done_vec
);
  typedef enum logic [1:0] {IDLE, PUSH_SR, PUSH_PC, FETCH} st_t;

  localparam logic [VW-1:0] AEV = VW'(AE_VEC);

  st_t           st;
  logic [VW-1:0] vec;
  logic [31:0]   sr_q, pc_q, sp_q, vbr_q;
  logic          ae, pend;

  wire stack_mis = sp_q[1:0] != 2'b00;
  wire base_mis  = vbr_q[1:0] != 2'b00;
  wire fin       = (bus_we | bus_re) & bus_ready;

  assign busy      = st != IDLE;
  assign bus_we    = st == PUSH_SR || st == PUSH_PC;
  assign bus_re    = st == FETCH;
  assign bus_addr  = bus_re ? vbr_q + {{(30-VW){1'b0}}, vec, 2'b00} : sp_q - 32'd4;
  assign bus_wdata = st == PUSH_SR ? sr_q : pc_q;
  assign sp_out    = sp_q;
  assign addr_err  = pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      vec      <= '0;
      sr_q     <= '0;
      pc_q     <= '0;
      sp_q     <= '0;
      vbr_q    <= '0;
      ae       <= 1'b0;
      pend     <= 1'b0;
      done     <= 1'b0;
      handler  <= '0;
      done_vec <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (req) begin
          vec   <= req_vec;
          sr_q  <= sr_in;
          pc_q  <= pc_in;
          sp_q  <= sp_in;
          vbr_q <= vbr_in;
          ae    <= 1'b0;
          st    <= PUSH_SR;
        end
        PUSH_SR, PUSH_PC: if (fin) begin
          sp_q <= sp_q - 32'd4;
          if (!ae && stack_mis) pend <= 1'b1;
          st <= (st == PUSH_SR) ? PUSH_PC : FETCH;
        end
        FETCH: if (fin) begin
          if (!ae && (pend || base_mis)) begin
            ae   <= 1'b1;
            pend <= 1'b0;
            vec  <= AEV;
            pc_q <= bus_rdata;
            st   <= PUSH_SR;
          end else begin
            done     <= 1'b1;
            handler  <= bus_rdata;
            done_vec <= vec;
            ae       <= 1'b0;
            st       <= IDLE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  a_r4_hold_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we | bus_re) && !bus_ready |=> $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we) && $stable(bus_re));
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_no_nested_fault: assert property (@(posedge clk) disable iff (!rst_n)
    ae |-> !pend);
  a_r8_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(bus_re && bus_ready) |=> $stable(vec));
  a_r9_low_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_ready |=> sp_out[1:0] == $past(sp_out[1:0]));
  a_r7_clear_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !addr_err);
endmodule

// File: tb/sim_exc_stacker.sv
module sim_exc_stacker;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 8;
  localparam int AE_VEC = 9;
  localparam logic [31:0] KEY = 32'hC3A5_0F00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [VW-1:0] req_vec = '0;
  logic [31:0] sr_in = '0, pc_in = '0, sp_in = '0, vbr_in = '0;
  logic busy, bus_we, bus_re, addr_err, done;
  logic [31:0] bus_addr, bus_wdata, sp_out, handler;
  logic [VW-1:0] done_vec;
  logic bus_ready = 1'b0;
  logic [31:0] bus_rdata;

  assign bus_rdata = bus_addr ^ KEY;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_stacker #(.VW(VW), .AE_VEC(AE_VEC)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_vec(req_vec), .sr_in(sr_in),
    .pc_in(pc_in), .sp_in(sp_in), .vbr_in(vbr_in), .busy(busy),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .sp_out(sp_out),
    .addr_err(addr_err), .done(done), .handler(handler), .done_vec(done_vec));

  int checks = 0, fails = 0, cycles = 0;
  int lat = 0, wc = 0, ntx = 0;
  logic [31:0] t_addr [0:15];
  logic [31:0] t_data [0:15];
  logic        t_we   [0:15];
  logic        t_err  [0:15];
  logic        t_hold [0:15];
  logic [31:0] first_addr;

  task automatic chk(input bit ok, input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (bus_we | bus_re) begin
      if (wc == 0) first_addr = bus_addr;
      if (wc >= lat) begin
        bus_ready = 1'b1;
        if (ntx < 16) begin
          t_addr[ntx] = bus_addr;
          t_data[ntx] = bus_wdata;
          t_we[ntx]   = bus_we;
          t_err[ntx]  = addr_err;
          t_hold[ntx] = (first_addr == bus_addr);
        end
        ntx++;
        wc = 0;
      end else begin
        bus_ready = 1'b0;
        wc++;
      end
    end else begin
      bus_ready = 1'b0;
      wc = 0;
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic run(input logic [31:0] sp, input logic [31:0] vb, input logic [VW-1:0] v, input int l);
    bit fault, spmis;
    int ndone, n, exp_n;
    logic [31:0] h1, h2, fsp;
    logic [VW-1:0] fv;
    lat = l;
    ntx = 0;
    ndone = 0;
    @(negedge clk);
    req = 1'b1; req_vec = v; sp_in = sp; vbr_in = vb;
    sr_in = {16'h5A00, 8'h00, v}; pc_in = 32'h0100_0000 + {24'h0, v};
    @(negedge clk);
    req = 1'b0; req_vec = 8'd77; sp_in = 32'hDEAD_0000;
    n = 0;
    while (!done && n < 200) begin
      if (n == 3) req = 1'b1;
      if (n == 4) req = 1'b0;
      @(negedge clk);
      n++;
    end
    req = 1'b0;
    spmis = sp[1:0] != 2'b00;
    fault = spmis || vb[1:0] != 2'b00;
    chk(done, "R3 done seen", {31'b0, done}, 32'd1);
    h1 = (vb + {22'b0, v, 2'b00}) ^ KEY;
    h2 = (vb + 32'(AE_VEC*4)) ^ KEY;
    fsp = fault ? sp - 32'd16 : sp - 32'd8;
    fv = fault ? 8'(AE_VEC) : v;
    chk(handler == (fault ? h2 : h1), fault ? "R7 handler" : "R3 handler", handler, fault ? h2 : h1);
    chk(done_vec == fv, fault ? "R7 done_vec" : "R3/R8 done_vec", {24'b0, done_vec}, {24'b0, fv});
    chk(sp_out == fsp, fault ? "R7 sp_out" : "R3 sp_out", sp_out, fsp);
    chk(sp_out[1:0] == sp[1:0], "R9 low bits", {30'b0, sp_out[1:0]}, {30'b0, sp[1:0]});
    chk(!addr_err, "R7 addr_err clear", {31'b0, addr_err}, 32'd0);
    exp_n = fault ? 6 : 3;
    chk(ntx == exp_n, "R6/R8 bus cycle count", ntx, exp_n);
    if (ntx >= 3) begin
      chk(t_we[0] && t_addr[0] == sp - 32'd4, "R2/R5 first write addr", t_addr[0], sp - 32'd4);
      chk(t_we[1] && t_addr[1] == sp - 32'd8, "R2/R5 second write addr", t_addr[1], sp - 32'd8);
      chk(!t_we[2] && t_addr[2] == (vb + {22'b0, v, 2'b00}), "R3 vector read addr", t_addr[2], vb + {22'b0, v, 2'b00});
      chk(t_err[2] == spmis, "R6 pending flag at read", {31'b0, t_err[2]}, {31'b0, spmis});
      if (!spmis) begin
        chk(t_data[0] == {16'h5A00, 8'h00, v}, "R2 sr data", t_data[0], {16'h5A00, 8'h00, v});
        chk(t_data[1] == 32'h0100_0000 + {24'h0, v}, "R2 pc data", t_data[1], 32'h0100_0000 + {24'h0, v});
      end
      for (int i = 0; i < 3; i++) chk(t_hold[i], "R4 address held", t_addr[i], first_addr);
    end
    if (fault && ntx >= 6) begin
      chk(t_we[3] && t_addr[3] == sp - 32'd12, "R6 ae sr addr", t_addr[3], sp - 32'd12);
      chk(t_we[4] && t_addr[4] == sp - 32'd16, "R6 ae pc addr", t_addr[4], sp - 32'd16);
      chk(!t_we[5] && t_addr[5] == vb + 32'(AE_VEC*4), "R6 ae read addr", t_addr[5], vb + 32'(AE_VEC*4));
      if (!spmis) chk(t_data[4] == h1, "R6 ae pushes handler", t_data[4], h1);
      chk(!t_err[3] && !t_err[5], "R7 no nested fault", {31'b0, t_err[5]}, 32'd0);
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (done) ndone++;
    end
    chk(ndone == 0 && !busy, "R8 no extra sequence", ndone, 0);
  endtask

  initial begin
    #(CLK_PERIOD*2 + 1);
    chk(!busy && !bus_we && !bus_re && !done && !addr_err && sp_out == 0, "R1 reset state", sp_out, 0);
    rst_n = 1'b1;
    for (int s = 0; s < 4; s++)
      for (int b = 0; b < 4; b++)
        for (int k = 0; k < 3; k++)
          for (int l = 0; l < 3; l++)
            run(32'h0000_8000 + 32'(s), 32'h0000_1000 + 32'(b),
                k == 0 ? 8'd0 : (k == 1 ? 8'd5 : 8'd255), l);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule